// File: doc/BRIEF.md
# Smooth Candidate Enumerator with Zero-Word Detection

This block walks through every product of a starting value with non-negative powers of a small fixed set of odd primes, staying below an upper magnitude limit of 2^U. Each product that lies strictly between 2^L and 2^U is screened for a machine word (WORD bits wide, 32 by default) that is entirely zero. Only words below the most significant nonzero word count. Every product that passes is offered on a valid/ready output stream, and a running count of passes is kept.

The walk is an odometer over the prime exponents. The exponent of the last prime turns fastest. When a product reaches the upper limit, the next lower prime position is bumped, and every faster position restarts from the bumped value. Software pulses `start` with a seed below 2^U. It drains the stream and waits for `done`, which stays high together with the final count until the next `start`. The multiplications use a constant-by-wide-value unit whose pipeline depth is a parameter.

Top module: `smooth_enum`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid`, `done` and `busy` are low and `found_count` is zero.
- R2: The emitted values follow lexicographic order of the exponent vector (e_0, ..., e_(NP-1)). The exponent of the last prime varies fastest. Prime index 0 is the least significant PRIMES field, and the order of the set is exactly the set of qualifying products seed·∏p_i^e_i that are below 2^U.
- R3: A value is emitted only if it is strictly greater than 2^L and strictly less than 2^U. A product equal to 2^L is never emitted.
- R4: A value qualifies only if some WORD-bit word lies strictly below its most significant nonzero word and is zero. Zero words above the top nonzero word do not count.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R6: `found_count` rises by exactly one for each value that is emitted. When `done` rises, it equals the number of values emitted since `start`.
- R7: When the walk has no further position to bump, `done` goes high and `busy` goes low. `done` stays high, with no valid output, until the next `start`.
- R8: A `start` accepted while idle or done loads the seed, clears `found_count` and `done`, and raises `busy` on the next cycle. A seed that is already inside the window is itself the first candidate tested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk from `seed`; ignored while busy |
| seed | input | U | Starting value, below 2^U |
| out_valid | output | 1 | A qualifying candidate is offered |
| out_ready | input | 1 | Consumer accepts the offered candidate |
| out_data | output | U | Offered candidate value |
| found_count | output | CW | Number of candidates emitted in this walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished; `found_count` is final |

## Verification
The bench compares the full emitted sequence with a nested-loop enumeration for several seeds in a narrow window with 4-bit words. Such a window makes zero words frequent enough to matter. The directed seeds include one equal to 2^L. A design that used a non-strict lower bound would emit that seed. Another directed seed has leading zero words but no interior ones. A design that counted leading words would emit it. A seed so large that a single multiplication leaves the window checks that the walk ends after one test with the right count. Random backpressure targets a design that drops or changes a stalled value, which would show up as a missing or altered entry in the sequence. A late `done` or a stale count at `done` would show up as a count mismatch.

// File: rtl/smooth_enum_pkg.sv
package smooth_enum_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TEST,
    ST_EMIT,
    ST_MUL,
    ST_WALK,
    ST_DONE
  } walk_state_t;
endpackage

// File: rtl/smooth_cmul.sv
module smooth_cmul #(
  parameter int W   = 488,
  parameter int NP  = 5,
  parameter int PW  = 8,
  parameter logic [NP*PW-1:0] PRIMES = {8'd13, 8'd11, 8'd7, 8'd5, 8'd3},
  parameter int LAT = 2,
  localparam int SW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_val,
  input  logic [SW-1:0] in_sel,
  output logic          out_valid,
  output logic [W-1:0]  out_val
);
  logic [PW-1:0] ptab [NP];
  logic [W-1:0]  sv   [LAT];
  logic          vv   [LAT];

  for (genvar g = 0; g < NP; g++) begin : g_ptab
    assign ptab[g] = PRIMES[g*PW +: PW];
  end

  always_ff @(posedge clk) begin
    if (rst) vv[0] <= 1'b0;
    else     vv[0] <= in_valid;
    sv[0] <= in_val * {{(W-PW){1'b0}}, ptab[in_sel]};
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) vv[s] <= 1'b0;
      else     vv[s] <= vv[s-1];
      sv[s] <= sv[s-1];
    end
  end

  assign out_valid = vv[LAT-1];
  assign out_val   = sv[LAT-1];
endmodule

// File: rtl/smooth_zscan.sv
module smooth_zscan #(
  parameter int W    = 488,
  parameter int WORD = 32,
  localparam int NW  = (W + WORD - 1) / WORD
) (
  input  logic [W-1:0] x,
  output logic         hit
);
  logic [NW*WORD-1:0] xp;
  logic [NW-1:0]      zero_w;
  logic [NW-1:0]      above_nz;

  assign xp = {{(NW*WORD-W){1'b0}}, x};

  for (genvar i = 0; i < NW; i++) begin : g_word
    assign zero_w[i] = ~|xp[i*WORD +: WORD];
    if (i < NW-1) begin : g_up
      assign above_nz[i] = |xp[NW*WORD-1 : (i+1)*WORD];
    end else begin : g_top
      assign above_nz[i] = 1'b0;
    end
  end

  assign hit = |(zero_w & above_nz);
endmodule

// File: rtl/smooth_enum.sv
module smooth_enum
  import smooth_enum_pkg::*;
#(
  parameter int L    = 352,
  parameter int U    = 480,
  parameter int WORD = 32,
  parameter int NP   = 5,
  parameter int PW   = 8,
  parameter logic [NP*PW-1:0] PRIMES = {8'd13, 8'd11, 8'd7, 8'd5, 8'd3},
  parameter int LAT  = 2,
  parameter int CW   = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [U-1:0]  seed,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [U-1:0]  out_data,
  output logic [CW-1:0] found_count,
  output logic          busy,
  output logic          done
);
  localparam int W  = U + PW;
  localparam int KW = (NP > 1) ? $clog2(NP) : 1;
  localparam logic [W-1:0] LO = {{(W-1){1'b0}}, 1'b1} << L;
  localparam logic [W-1:0] HI = {{(W-1){1'b0}}, 1'b1} << U;

  walk_state_t   state;
  logic [W-1:0]  cval [NP];
  logic [KW-1:0] kidx;
  logic          mul_go;
  logic [W-1:0]  mul_a;
  logic [KW-1:0] mul_sel;
  logic          mul_vld;
  logic [W-1:0]  mul_res;
  logic [W-1:0]  cur;
  logic          zhit;
  logic          in_win;
  logic          hit;

  assign cur    = cval[NP-1];
  assign in_win = (cur > LO) && (cur < HI);
  assign hit    = in_win && zhit;

  smooth_zscan #(.W(W), .WORD(WORD)) u_zscan (
    .x   (cur),
    .hit (zhit)
  );

  smooth_cmul #(.W(W), .NP(NP), .PW(PW), .PRIMES(PRIMES), .LAT(LAT)) u_cmul (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (mul_go),
    .in_val    (mul_a),
    .in_sel    (mul_sel),
    .out_valid (mul_vld),
    .out_val   (mul_res)
  );

  always_ff @(posedge clk) begin
    mul_go <= 1'b0;
    if (rst) begin
      state       <= ST_IDLE;
      out_valid   <= 1'b0;
      done        <= 1'b0;
      busy        <= 1'b0;
      found_count <= '0;
      kidx        <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            for (int j = 0; j < NP; j++) cval[j] <= W'(seed);
            found_count <= '0;
            done        <= 1'b0;
            busy        <= 1'b1;
            state       <= ST_TEST;
          end
        end
        ST_TEST: begin
          if (hit) begin
            out_valid   <= 1'b1;
            out_data    <= cur[U-1:0];
            found_count <= found_count + CW'(1);
            state       <= ST_EMIT;
          end else begin
            mul_go  <= 1'b1;
            mul_a   <= cur;
            mul_sel <= KW'(NP-1);
            kidx    <= KW'(NP-1);
            state   <= ST_MUL;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            mul_go    <= 1'b1;
            mul_a     <= cur;
            mul_sel   <= KW'(NP-1);
            kidx      <= KW'(NP-1);
            state     <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (mul_vld) begin
            if (mul_res >= HI) begin
              cval[kidx] <= mul_res;
              state      <= ST_WALK;
            end else begin
              for (int j = 0; j < NP; j++)
                if (j >= int'(kidx)) cval[j] <= mul_res;
              state <= ST_TEST;
            end
          end
        end
        ST_WALK: begin
          if (kidx == '0) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_DONE;
          end else begin
            kidx    <= kidx - KW'(1);
            mul_go  <= 1'b1;
            mul_a   <= cval[kidx - KW'(1)];
            mul_sel <= kidx - KW'(1);
            state   <= ST_MUL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smooth_enum_chk.sv
module smooth_enum_chk #(
  parameter int L  = 352,
  parameter int U  = 480,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          out_valid,
  input logic          out_ready,
  input logic [U-1:0]  out_data,
  input logic [CW-1:0] found_count,
  input logic          busy,
  input logic          done
);
  localparam logic [U:0] LO = {{U{1'b0}}, 1'b1} << L;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!out_valid && !done && !busy && found_count == '0));

  a_r3_window: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, out_data} > LO));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (found_count == $past(found_count) + CW'(1)));

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !out_valid));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

bind smooth_enum smooth_enum_chk #(.L(L), .U(U), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .found_count (found_count),
  .busy        (busy),
  .done        (done)
);

// File: tb/smooth_enum_test.sv
`timescale 1ns/1ps
module smooth_enum_test;
  localparam int L = 24;
  localparam int U = 40;
  localparam int CW = 32;
  localparam logic [63:0] LIM = 64'h1 << U;
  localparam logic [63:0] LOW = 64'h1 << L;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [U-1:0]  seed = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [U-1:0]  out_data;
  logic [CW-1:0] found_count;
  logic          busy;
  logic          done;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_q[$];
  logic [63:0] got_q[$];
  bit collect = 1'b0;
  bit stalled = 1'b0;
  logic [U-1:0] stall_data;

  always #2 clk = ~clk;

  smooth_enum #(.L(L), .U(U), .WORD(4), .NP(5), .PW(8),
                .PRIMES({8'd13, 8'd11, 8'd7, 8'd5, 8'd3}), .LAT(2), .CW(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .seed(seed),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .found_count(found_count), .busy(busy), .done(done));

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic bit zero_nibble(logic [63:0] v);
    int top = -1;
    for (int i = 0; i < 16; i++) if (v[i*4 +: 4] != 4'h0) top = i;
    for (int i = 0; i < top; i++) if (v[i*4 +: 4] == 4'h0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic build_expected(logic [63:0] sd);
    logic [63:0] v0, v1, v2, v3, v4;
    exp_q.delete();
    v0 = sd;
    while (v0 < LIM) begin
      v1 = v0;
      while (v1 < LIM) begin
        v2 = v1;
        while (v2 < LIM) begin
          v3 = v2;
          while (v3 < LIM) begin
            v4 = v3;
            while (v4 < LIM) begin
              if (v4 > LOW && zero_nibble(v4)) exp_q.push_back(v4);
              v4 = v4 * 13;
            end
            v3 = v3 * 11;
          end
          v2 = v2 * 7;
        end
        v1 = v1 * 5;
      end
      v0 = v0 * 3;
    end
  endtask

  // consumer with random backpressure; R5 hold check
  always @(negedge clk) begin
    if (collect) begin
      if (stalled)
        check(out_valid && out_data == stall_data, "R5", "stalled output held",
              {24'h0, out_data}, {24'h0, stall_data});
      out_ready = ($urandom_range(0, 3) != 0);
      if (out_valid && out_ready) got_q.push_back({24'h0, out_data});
      stalled = out_valid && !out_ready;
      stall_data = out_data;
    end
  end

  task automatic run_seed(logic [63:0] sd, string tag);
    build_expected(sd);
    got_q.delete();
    @(negedge clk);
    seed = sd[U-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && found_count == 0, "R8", {tag, " start loads and clears"},
          {busy, done, found_count}, {2'b10, 32'h0});
    collect = 1'b1;
    while (!done) @(negedge clk);
    @(negedge clk);
    collect = 1'b0;
    stalled = 1'b0;
    out_ready = 1'b0;
    check(found_count == exp_q.size(), "R6", {tag, " final count"}, found_count, exp_q.size());
    check(got_q.size() == exp_q.size(), "R2", {tag, " emitted count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], "R2", {tag, " sequence entry"}, got_q[i], exp_q[i]);
    repeat (3) @(negedge clk);
    check(done && !busy && !out_valid, "R7", {tag, " done held idle"},
          {done, busy, out_valid}, 3'b100);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!out_valid && !done && !busy && found_count == 0, "R1", "reset state",
          {out_valid, done, busy, found_count}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !done && !busy, "R1", "idle after reset",
          {out_valid, done, busy}, 0);

    // R3: seed equal to the lower bound is not emitted
    run_seed(64'h1 << L, "lower-bound seed");
    seen = 1'b0;
    foreach (got_q[i]) if (got_q[i] == LOW) seen = 1'b1;
    check(!seen, "R3", "value equal to 2^L not emitted", seen, 0);

    // R4: leading zero words only, no interior zero -> seed itself not emitted
    run_seed(64'h1_1111_1111, "leading-zero seed");
    seen = 1'b0;
    foreach (got_q[i]) if (got_q[i] == 64'h1_1111_1111) seen = 1'b1;
    check(!seen, "R4", "leading zero words do not qualify", seen, 0);

    // R8/R6: in-window seed, one test then the walk ends
    run_seed(64'h80_0000_0001, "single hit");
    check(found_count == 1, "R6", "single in-window seed counted once", found_count, 1);
    run_seed(64'h77_7777_7777, "single miss");
    check(found_count == 0, "R4", "no zero word gives no hit", found_count, 0);

    run_seed(64'h101, "small seed");
    for (int r = 0; r < 4; r++)
      run_seed(64'($urandom_range(16384, 4194303)), "random seed");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule